// File: doc/BRIEF.md
# Extended Rounding and Precision Coercion Unit

This block takes an unrounded arithmetic result and coerces it to one of three destination precisions: a 64-bit significand (extended), 53 bits (double) or 24 bits (single). The result arrives as a sign, a signed 32-bit exponent, a normalized 64-bit significand and a 16-bit guard/sticky word that holds the bits already lost below the significand.

Coercion runs in four stages. A result whose exponent is below the precision's lower limit is first denormalized. The bits below the target precision are then folded into the guard/sticky word. The result is rounded under one of four directions. Finally, a result whose exponent exceeds the precision's upper limit is replaced by infinity or by the largest finite value. The unit raises underflow, overflow, inexact and round-incremented flags with the result.

A caller presents the operands together with a one-cycle `start_i` pulse. The result and flags are registered on that edge and `done_o` pulses in the following cycle. The outputs then hold until the next start.

Top module: `fp_coerce_unit`

## Requirements
- R1: While `rst_ni` is low, `done_o`, every flag, `sign_o`, `exp_o` and `sig_o` are zero.
- R2: The unit registers a result on each clock edge that samples `start_i` high, and `done_o` is high exactly in the cycle after that edge. While `start_i` stays low the outputs do not change, whatever the other inputs do.
- R3: The lower exponent limit is 0 for extended, 0x3C01 for double and 0x3F81 for single. When the input exponent is below the limit, the unit sets the exponent to the limit and shifts the {significand, guard word} pair right by the difference. Shift counts above 66 are capped at 66, and every bit shifted out is ORed into guard bit 0.
- R4: `prec_i` selects the precision: bit 1 set means single, otherwise bit 0 set means double, otherwise extended. For double and single, the significand bits below the target LSB (bit 11 for double, bit 40 for single) are cleared. The guard word then becomes {highest discarded bit, 14 zero bits, OR of the remaining discarded bits and the old guard word}.
- R5: `rmode_i` selects the rounding direction: 00 to nearest, 01 toward +infinity, 10 toward -infinity, 11 toward zero. Toward +infinity rounds up only positive values, toward -infinity only negative values, and toward zero never rounds up.
- R6: In nearest mode, a guard word above 0x8000 rounds up. A guard word of exactly 0x8000 rounds up only when the target LSB of the significand is 1.
- R7: When the final guard word is zero, the result is not rounded and both the underflow and inexact flags are clear. A nonzero guard word sets inexact.
- R8: A round-up adds one unit at the target LSB and sets `inc_o`. If the addition carries out of bit 63, the significand becomes 1 followed by the upper 63 bits of the sum, and the exponent is incremented.
- R9: The upper exponent limit is 0x7FFE for extended, 0x43FE for double and 0x407E for single. A rounded exponent above the limit sets both `of_o` and `nx_o`.
- R10: An overflowed result is infinity (exponent 0x7FFF, zero significand) in nearest mode, in toward-+infinity mode with a positive sign, and in toward--infinity mode with a negative sign. In every other case it is the largest finite value: the upper limit as exponent and all ones from bit 63 down to the target LSB.
- R11: `sign_o` equals the sign sampled with the start pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Sample operands and produce a result |
| prec_i | input | 2 | Destination precision select |
| rmode_i | input | 2 | Rounding direction |
| sign_i | input | 1 | Result sign |
| exp_i | input | 32 | Signed unbiased-internal exponent |
| sig_i | input | 64 | Normalized significand |
| grd_i | input | 16 | Guard/sticky word below the significand |
| done_o | output | 1 | Result valid pulse |
| sign_o | output | 1 | Coerced sign |
| exp_o | output | 32 | Coerced exponent |
| sig_o | output | 64 | Coerced significand |
| uf_o | output | 1 | Underflow flag |
| of_o | output | 1 | Overflow flag |
| nx_o | output | 1 | Inexact flag |
| inc_o | output | 1 | Significand was rounded up |

## Verification
The bench builds the unit with its default parameters: a 64-bit significand, a 16-bit guard word, a 32-bit exponent and a shift cap of 66. At these values the real limit exponents apply, so the sweep can place exponents just under, on and just over each of the six limits. It also reaches the 65-bit and capped 66-bit shifts and the extremes of the signed exponent range. The significand patterns are chosen to hit the guard bit of each precision, the ties to even and the all-ones carry. Every combination of precision code, direction and sign is crossed with them, and each result is compared against an arithmetic model built from the requirements.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_UP   = 2'b01,
    RM_DOWN = 2'b10,
    RM_ZERO = 2'b11
  } rmode_e;

  typedef enum logic [1:0] {
    PR_EXT = 2'd0,
    PR_DBL = 2'd1,
    PR_SGL = 2'd2
  } prec_e;

  function automatic prec_e decode_prec(input logic [1:0] code);
    if (code[1]) return PR_SGL;
    if (code[0]) return PR_DBL;
    return PR_EXT;
  endfunction

  // overflow result is infinity rather than largest finite
  function automatic logic ovf_to_inf(input rmode_e rm, input logic neg);
    return (rm == RM_NEAR) || (rm == RM_UP && !neg) || (rm == RM_DOWN && neg);
  endfunction

endpackage

// File: rtl/fpc_denorm.sv
module fpc_denorm #(
  parameter int SIG_W     = 64,
  parameter int GRD_W     = 16,
  parameter int EXP_W     = 32,
  parameter int SHIFT_CAP = 66
) (
  input  logic [EXP_W-1:0] exp_i,
  input  logic [EXP_W-1:0] thr_i,
  input  logic [SIG_W-1:0] sig_i,
  input  logic [GRD_W-1:0] grd_i,
  output logic [EXP_W-1:0] exp_o,
  output logic [SIG_W-1:0] sig_o,
  output logic [GRD_W-1:0] grd_o,
  output logic             uf_o
);
  localparam int WIDE_W = SIG_W + GRD_W;
  localparam int CNT_W  = $clog2(SHIFT_CAP + 1);

  logic signed [EXP_W:0] diff;
  logic [CNT_W-1:0]      shamt;
  logic [WIDE_W-1:0]     wide, shifted, lost_mask;
  logic                  lost;

  always_comb begin
    diff      = {thr_i[EXP_W-1], thr_i} - {exp_i[EXP_W-1], exp_i};
    uf_o      = diff > 0;
    shamt     = (diff > (EXP_W+1)'(SHIFT_CAP)) ? CNT_W'(SHIFT_CAP) : diff[CNT_W-1:0];
    wide      = {sig_i, grd_i};
    shifted   = wide >> shamt;
    lost_mask = ~({WIDE_W{1'b1}} << shamt);
    lost      = |(wide & lost_mask);
    exp_o     = exp_i;
    sig_o     = sig_i;
    grd_o     = grd_i;
    if (uf_o) begin
      exp_o = thr_i;
      sig_o = shifted[WIDE_W-1:GRD_W];
      grd_o = shifted[GRD_W-1:0] | {{(GRD_W-1){1'b0}}, lost};
    end
  end

endmodule

// File: rtl/fpc_fold.sv
module fpc_fold #(
  parameter int SIG_W = 64,
  parameter int GRD_W = 16,
  localparam int POS_W = $clog2(SIG_W)
) (
  input  logic [POS_W-1:0] lsb_i,
  input  logic [SIG_W-1:0] sig_i,
  input  logic [GRD_W-1:0] grd_i,
  output logic [SIG_W-1:0] sig_o,
  output logic [GRD_W-1:0] grd_o
);
  logic [SIG_W-1:0] below, rest;

  always_comb begin
    below = ~({SIG_W{1'b1}} << lsb_i);
    rest  = below >> 1;
    sig_o = sig_i & ~below;
    grd_o = grd_i;
    if (lsb_i != '0) begin
      grd_o          = '0;
      grd_o[GRD_W-1] = |(sig_i & below & ~rest);
      grd_o[0]       = (|(sig_i & rest)) | (|grd_i);
    end
  end

endmodule

// File: rtl/fpc_round.sv
module fpc_round
  import fpc_pkg::*;
#(
  parameter int SIG_W = 64,
  parameter int GRD_W = 16,
  parameter int EXP_W = 32,
  localparam int POS_W = $clog2(SIG_W)
) (
  input  logic             sign_i,
  input  rmode_e           rmode_i,
  input  logic [POS_W-1:0] lsb_i,
  input  logic [EXP_W-1:0] exp_i,
  input  logic [SIG_W-1:0] sig_i,
  input  logic [GRD_W-1:0] grd_i,
  output logic [EXP_W-1:0] exp_o,
  output logic [SIG_W-1:0] sig_o,
  output logic             inc_o,
  output logic             exact_o
);
  localparam logic [GRD_W-1:0] HALF = {1'b1, {(GRD_W-1){1'b0}}};

  logic [SIG_W:0] unit, sum;
  logic           lsb_bit, up;

  always_comb begin
    unit    = {{SIG_W{1'b0}}, 1'b1} << lsb_i;
    lsb_bit = |(sig_i & unit[SIG_W-1:0]);
    exact_o = (grd_i == '0);
    unique case (rmode_i)
      RM_NEAR: up = (grd_i > HALF) || ((grd_i == HALF) && lsb_bit);
      RM_UP:   up = !sign_i;
      RM_DOWN: up = sign_i;
      default: up = 1'b0;
    endcase
    if (exact_o) up = 1'b0;
    sum   = {1'b0, sig_i} + unit;
    inc_o = up;
    exp_o = exp_i;
    sig_o = sig_i;
    if (up) begin
      if (sum[SIG_W]) begin
        sig_o = sum[SIG_W:1];
        exp_o = exp_i + 1'b1;
      end else begin
        sig_o = sum[SIG_W-1:0];
      end
    end
  end

endmodule

// File: rtl/fpc_ovf.sv
module fpc_ovf
  import fpc_pkg::*;
#(
  parameter int SIG_W   = 64,
  parameter int EXP_W   = 32,
  parameter int EXP_MAX = 32'h7FFF,
  localparam int POS_W  = $clog2(SIG_W)
) (
  input  logic             sign_i,
  input  rmode_e           rmode_i,
  input  logic [POS_W-1:0] lsb_i,
  input  logic [EXP_W-1:0] thr_i,
  input  logic [EXP_W-1:0] exp_i,
  input  logic [SIG_W-1:0] sig_i,
  output logic [EXP_W-1:0] exp_o,
  output logic [SIG_W-1:0] sig_o,
  output logic             of_o
);
  always_comb begin
    of_o  = $signed(exp_i) > $signed(thr_i);
    exp_o = exp_i;
    sig_o = sig_i;
    if (of_o) begin
      if (ovf_to_inf(rmode_i, sign_i)) begin
        exp_o = EXP_W'(EXP_MAX);
        sig_o = '0;
      end else begin
        exp_o = thr_i;
        sig_o = {SIG_W{1'b1}} << lsb_i;
      end
    end
  end

endmodule

// File: rtl/fp_coerce_unit.sv
module fp_coerce_unit
  import fpc_pkg::*;
#(
  parameter int SIG_W     = 64,
  parameter int GRD_W     = 16,
  parameter int EXP_W     = 32,
  parameter int DBL_W     = 53,
  parameter int SGL_W     = 24,
  parameter int SHIFT_CAP = 66,
  parameter int UF_EXT    = 0,
  parameter int UF_DBL    = 32'h3C01,
  parameter int UF_SGL    = 32'h3F81,
  parameter int OF_EXT    = 32'h7FFE,
  parameter int OF_DBL    = 32'h43FE,
  parameter int OF_SGL    = 32'h407E,
  parameter int EXP_MAX   = 32'h7FFF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [1:0]       prec_i,
  input  logic [1:0]       rmode_i,
  input  logic             sign_i,
  input  logic [EXP_W-1:0] exp_i,
  input  logic [SIG_W-1:0] sig_i,
  input  logic [GRD_W-1:0] grd_i,
  output logic             done_o,
  output logic             sign_o,
  output logic [EXP_W-1:0] exp_o,
  output logic [SIG_W-1:0] sig_o,
  output logic             uf_o,
  output logic             of_o,
  output logic             nx_o,
  output logic             inc_o
);
  localparam int POS_W   = $clog2(SIG_W);
  localparam int LSB_EXT = 0;
  localparam int LSB_DBL = SIG_W - DBL_W;
  localparam int LSB_SGL = SIG_W - SGL_W;

  prec_e            prec;
  rmode_e           rmode;
  logic [EXP_W-1:0] uf_thr, of_thr;
  logic [POS_W-1:0] lsb;

  always_comb begin
    prec  = decode_prec(prec_i);
    rmode = rmode_e'(rmode_i);
    unique case (prec)
      PR_SGL: begin
        uf_thr = EXP_W'(UF_SGL);
        of_thr = EXP_W'(OF_SGL);
        lsb    = POS_W'(LSB_SGL);
      end
      PR_DBL: begin
        uf_thr = EXP_W'(UF_DBL);
        of_thr = EXP_W'(OF_DBL);
        lsb    = POS_W'(LSB_DBL);
      end
      default: begin
        uf_thr = EXP_W'(UF_EXT);
        of_thr = EXP_W'(OF_EXT);
        lsb    = POS_W'(LSB_EXT);
      end
    endcase
  end

  logic [EXP_W-1:0] dn_exp, rn_exp, ov_exp;
  logic [SIG_W-1:0] dn_sig, fd_sig, rn_sig, ov_sig;
  logic [GRD_W-1:0] dn_grd, fd_grd;
  logic             dn_uf, rn_inc, rn_exact, ov_of;

  fpc_denorm #(
    .SIG_W(SIG_W), .GRD_W(GRD_W), .EXP_W(EXP_W), .SHIFT_CAP(SHIFT_CAP)
  ) i_denorm (
    .exp_i(exp_i), .thr_i(uf_thr), .sig_i(sig_i), .grd_i(grd_i),
    .exp_o(dn_exp), .sig_o(dn_sig), .grd_o(dn_grd), .uf_o(dn_uf)
  );

  fpc_fold #(
    .SIG_W(SIG_W), .GRD_W(GRD_W)
  ) i_fold (
    .lsb_i(lsb), .sig_i(dn_sig), .grd_i(dn_grd),
    .sig_o(fd_sig), .grd_o(fd_grd)
  );

  fpc_round #(
    .SIG_W(SIG_W), .GRD_W(GRD_W), .EXP_W(EXP_W)
  ) i_round (
    .sign_i(sign_i), .rmode_i(rmode), .lsb_i(lsb), .exp_i(dn_exp),
    .sig_i(fd_sig), .grd_i(fd_grd),
    .exp_o(rn_exp), .sig_o(rn_sig), .inc_o(rn_inc), .exact_o(rn_exact)
  );

  fpc_ovf #(
    .SIG_W(SIG_W), .EXP_W(EXP_W), .EXP_MAX(EXP_MAX)
  ) i_ovf (
    .sign_i(sign_i), .rmode_i(rmode), .lsb_i(lsb), .thr_i(of_thr),
    .exp_i(rn_exp), .sig_i(rn_sig),
    .exp_o(ov_exp), .sig_o(ov_sig), .of_o(ov_of)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o <= 1'b0;
      sign_o <= 1'b0;
      exp_o  <= '0;
      sig_o  <= '0;
      uf_o   <= 1'b0;
      of_o   <= 1'b0;
      nx_o   <= 1'b0;
      inc_o  <= 1'b0;
    end else begin
      done_o <= start_i;
      if (start_i) begin
        sign_o <= sign_i;
        exp_o  <= ov_exp;
        sig_o  <= ov_sig;
        uf_o   <= dn_uf & ~rn_exact;
        of_o   <= ov_of;
        nx_o   <= ~rn_exact | ov_of;
        inc_o  <= rn_inc;
      end
    end
  end

  AST_DONE_AFTER_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> done_o); // R2
  AST_NO_SPURIOUS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !done_o); // R2
  AST_RESULT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> ($stable(sig_o) && $stable(exp_o) && $stable(nx_o))); // R2
  AST_UF_ONLY_INEXACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uf_o |-> nx_o); // R7
  AST_INC_ONLY_INEXACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_o |-> nx_o); // R8
  AST_OF_RAISES_NX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    of_o |-> nx_o); // R9
  AST_OF_RESULT_FORM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    of_o |-> ((exp_o == EXP_W'(EXP_MAX) && sig_o == '0) || sig_o[SIG_W-1])); // R10

endmodule

// File: tb/test_fp_coerce_unit.sv
module test_fp_coerce_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  prec = '0;
  logic [1:0]  rmode = '0;
  logic        sign = 1'b0;
  logic [31:0] expv = '0;
  logic [63:0] sig = '0;
  logic [15:0] grd = '0;
  logic        done_o, sign_o, uf_o, of_o, nx_o, inc_o;
  logic [31:0] exp_o;
  logic [63:0] sig_o;

  int vectors = 0;
  int fails   = 0;
  bit ended   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fp_coerce_unit i_fp_coerce_unit (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .prec_i(prec), .rmode_i(rmode),
    .sign_i(sign), .exp_i(expv), .sig_i(sig), .grd_i(grd),
    .done_o(done_o), .sign_o(sign_o), .exp_o(exp_o), .sig_o(sig_o),
    .uf_o(uf_o), .of_o(of_o), .nx_o(nx_o), .inc_o(inc_o)
  );

  function automatic logic [100:0] actual();
    return {sign_o, exp_o, sig_o, uf_o, of_o, nx_o, inc_o};
  endfunction

  // reference built from the requirements: bitwise shifting and unit arithmetic
  function automatic logic [100:0] model(input logic s, input logic [31:0] e_in,
      input logic [63:0] m_in, input logic [15:0] g_in, input logic [1:0] p,
      input logic [1:0] rm);
    longint lo, hi, n;
    int k;
    logic [31:0] e;
    logic [63:0] m;
    logic [15:0] g;
    logic [64:0] sum;
    logic lost, uf, of, nx, inc, up, st, inf;
    if (p[1]) begin lo = 32'h3F81; hi = 32'h407E; k = 40; end
    else if (p[0]) begin lo = 32'h3C01; hi = 32'h43FE; k = 11; end
    else begin lo = 0; hi = 32'h7FFE; k = 0; end
    e = e_in; m = m_in; g = g_in;
    uf = 0; of = 0; nx = 0; inc = 0; up = 0;
    if (longint'($signed(e)) < lo) begin
      uf = 1;
      n = lo - longint'($signed(e));
      if (n > 66) n = 66;
      lost = 0;
      for (longint i = 0; i < n; i++) begin
        lost = lost | g[0];
        g = {m[0], g[15:1]};
        m = m >> 1;
      end
      g[0] = g[0] | lost;
      e = 32'(lo);
    end
    if (k > 0) begin
      st = |g;
      for (int i = 0; i < k - 1; i++) st = st | m[i];
      g = {m[k-1], 14'd0, st};
      for (int i = 0; i < k; i++) m[i] = 1'b0;
    end
    if (g == 16'd0) uf = 0;
    else begin
      nx = 1;
      case (rm)
        2'b00: up = (g > 16'h8000) || (g == 16'h8000 && m[k]);
        2'b01: up = !s;
        2'b10: up = s;
        default: up = 0;
      endcase
      if (up) begin
        inc = 1;
        sum = {1'b0, m} + (65'd1 << k);
        if (sum[64]) begin m = sum[64:1]; e = e + 32'd1; end
        else m = sum[63:0];
      end
    end
    if (longint'($signed(e)) > hi) begin
      of = 1; nx = 1;
      inf = (rm == 2'b00) || (rm == 2'b01 && !s) || (rm == 2'b10 && s);
      if (inf) begin e = 32'h7FFF; m = '0; end
      else begin e = 32'(hi); m = ~64'd0 << k; end
    end
    return {s, e, m, uf, of, nx, inc};
  endfunction

  task automatic check(input string req, input logic [100:0] act, input logic [100:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (prec %b rm %b s %b e %h m %h g %h)",
               req, act, exp, prec, rmode, sign, expv, sig, grd);
    end
  endtask

  task automatic apply(input logic [1:0] p, input logic [1:0] rm, input logic s,
                       input logic [31:0] e, input logic [63:0] m, input logic [15:0] g);
    @(negedge clk);
    prec = p; rmode = rm; sign = s; expv = e; sig = m; grd = g; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  function automatic string tag_for(input logic [100:0] a, input logic [100:0] x,
                                    input logic [1:0] p);
    if (a[2] !== x[2]) return "R9";
    if (a[3] !== x[3]) return "R7";
    if (a[0] !== x[0]) return "R8";
    if (a[1] !== x[1]) return "R7";
    if (a[100] !== x[100]) return "R11";
    if (x[2]) return "R10";
    if (x[3]) return "R3";
    if (p != 2'b00) return "R4";
    return "R5";
  endfunction

  function automatic logic [63:0] sig_pat(input int i);
    case (i)
      0: return 64'h8000_0000_0000_0000;
      1: return 64'hFFFF_FFFF_FFFF_FFFF;
      2: return 64'h8000_0000_0000_0400;
      3: return 64'h8000_0000_0000_0C00;
      4: return 64'h8000_0080_0000_0000;
      5: return 64'h8000_0180_0000_0000;
      6: return 64'hFFFF_FF80_0000_0000;
      7: return 64'hC5A3_91E7_0F1D_2B69;
      default: return 64'hFFFF_FFFF_FFFF_FC00;
    endcase
  endfunction

  function automatic logic [15:0] grd_pat(input int i);
    case (i)
      0: return 16'h0000;
      1: return 16'h8000;
      2: return 16'h8001;
      3: return 16'h7FFF;
      default: return 16'h0001;
    endcase
  endfunction

  logic [31:0] exps [30];

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] lows [3];
    logic [31:0] highs [3];
    logic [100:0] snap, x, a;
    int idx;
    lows = '{32'h0, 32'h3C01, 32'h3F81};
    highs = '{32'h7FFE, 32'h43FE, 32'h407E};
    idx = 0;
    for (int t = 0; t < 3; t++) begin
      exps[idx++] = lows[t] - 32'd70;
      exps[idx++] = lows[t] - 32'd66;
      exps[idx++] = lows[t] - 32'd65;
      exps[idx++] = lows[t] - 32'd1;
      exps[idx++] = lows[t];
      exps[idx++] = lows[t] + 32'd1;
      exps[idx++] = highs[t] - 32'd1;
      exps[idx++] = highs[t];
      exps[idx++] = highs[t] + 32'd1;
    end
    exps[27] = 32'h3FFF;
    exps[28] = 32'h8000_0000;
    exps[29] = 32'h7FFF_FFF0;

    // R1: reset state
    repeat (2) @(negedge clk);
    check("R1", {done_o, actual()}, 102'd0);
    rst_n = 1'b1;

    // R6: ties to even in nearest, extended
    apply(2'b00, 2'b00, 1'b0, 32'h3FFF, 64'h8000_0000_0000_0002, 16'h8000);
    check("R6", actual(), {1'b0, 32'h3FFF, 64'h8000_0000_0000_0002, 4'b0010});
    apply(2'b00, 2'b00, 1'b0, 32'h3FFF, 64'h8000_0000_0000_0003, 16'h8000);
    check("R6", actual(), {1'b0, 32'h3FFF, 64'h8000_0000_0000_0004, 4'b0011});

    // R8: carry out of bit 63 renormalizes and bumps the exponent
    apply(2'b00, 2'b00, 1'b1, 32'h3FFF, 64'hFFFF_FFFF_FFFF_FFFF, 16'h8001);
    check("R8", actual(), {1'b1, 32'h4000, 64'h8000_0000_0000_0000, 4'b0011});

    // R10: overflow toward zero gives largest finite, nearest gives infinity
    apply(2'b00, 2'b11, 1'b0, 32'h7FFF, 64'h8000_0000_0000_0000, 16'h0);
    check("R10", actual(), {1'b0, 32'h7FFE, 64'hFFFF_FFFF_FFFF_FFFF, 4'b0110});
    apply(2'b01, 2'b00, 1'b1, 32'h4400, 64'h8000_0000_0000_0000, 16'h0);
    check("R10", actual(), {1'b1, 32'h7FFF, 64'h0, 4'b0110});

    // R3: capped shift of 66, single, toward zero
    apply(2'b10, 2'b11, 1'b0, 32'h3F81 - 32'd80, 64'h8000_0000_0000_0000, 16'h0);
    check("R3", actual(), {1'b0, 32'h3F81, 64'h0, 4'b1010});

    // R7: exact tiny value keeps no flags (shift of 1, extended, low bit clear)
    apply(2'b00, 2'b00, 1'b0, 32'hFFFF_FFFF, 64'h8000_0000_0000_0000, 16'h0);
    check("R7", actual(), {1'b0, 32'h0, 64'h4000_0000_0000_0000, 4'b0000});

    // R2: done pulse and outputs held while inputs move without start
    apply(2'b00, 2'b01, 1'b0, 32'h3FFF, 64'h8000_0000_0000_0001, 16'h0001);
    check("R2", {done_o, 101'd0}, {1'b1, 101'd0});
    snap = actual();
    @(negedge clk);
    sig = 64'hFFFF_FFFF_FFFF_FFFF; grd = 16'hFFFF; expv = 32'h7FFF; rmode = 2'b00;
    @(negedge clk);
    check("R2", {done_o, actual()}, {1'b0, snap});

    // sweep: all precision codes, directions, signs, exponents, patterns
    for (int p = 0; p < 4; p++)
      for (int rm = 0; rm < 4; rm++)
        for (int s = 0; s < 2; s++)
          for (int ei = 0; ei < 30; ei++)
            for (int si = 0; si < 9; si++)
              for (int gi = 0; gi < 5; gi++) begin
                if (ended) break;
                apply(2'(p), 2'(rm), 1'(s), exps[ei], sig_pat(si), grd_pat(gi));
                x = model(1'(s), exps[ei], sig_pat(si), grd_pat(gi), 2'(p), 2'(rm));
                a = actual();
                if (!done_o) check("R2", {100'd0, done_o}, {100'd0, 1'b1});
                check(tag_for(a, x, 2'(p)), a, x);
              end

    if (!ended) begin
      ended = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule